// File: doc/BRIEF.md
# Ten-Bit Address I2C Receive Target

This block is the receive side of an I2C target that answers to a 10-bit bus address. It oversamples the SCL and SDA lines with the system clock and recognizes START, STOP and repeated START conditions. It matches the address against a configured 10-bit value. The address arrives as two bytes: a header byte that carries the two upper address bits and the direction bit, then a byte that carries the lower eight bits. Once both bytes match, the block acknowledges every data byte the controller writes and hands each one to the host.

The host sees the result as level flags plus one interrupt line: address matched, data ready, bus stop seen, the direction of the last header, data overrun, and a NAK that is armed for the next byte. The host clears flags with two read strobes, one for status and one for data. It can arm a Not-Acknowledge so that the next data byte ends the transfer. SDA is driven only as an open-drain pull-down enable. The block never drives SCL.

Top module: `i2c10_slave_rx`

## Requirements
- R1: After reset, sda_oe is 0, and rx_ready, overrun, addr_match, stop_seen, dir_read, nak_armed and irq are all 0.
- R2: A header byte after START is acknowledged only when it has bits [7:3] = 5'b11110, bits [2:1] equal to own_addr[9:8] and bit 0 = 0. Any other header is answered by releasing SDA (NAK), and all later bytes up to the next START are neither acknowledged nor stored.
- R3: When a header carries the right prefix and upper address bits, dir_read takes its bit 0. A header with bit 0 = 1 (read request) is not acknowledged and leaves dir_read at 1. A write header leaves it at 0.
- R4: The byte after an accepted header is acknowledged only when it equals own_addr[7:0]. It then sets addr_match and irq. On a mismatch it is NAKed, addr_match stays 0, and later data is ignored.
- R5: Each data byte in a matched transfer is acknowledged, appears on rx_data, and sets rx_ready and irq. A data_rd pulse clears rx_ready.
- R6: After a nak_set pulse, nak_armed reads 1. The next data byte is answered with NAK but is still stored with rx_ready set, and nak_armed then returns to 0 by itself. Data bytes after that NAK in the same transfer are ignored.
- R7: A STOP or a repeated START after an address match sets stop_seen and irq. A STOP on an unmatched transfer does not set it. A stat_rd pulse clears stop_seen, addr_match and overrun.
- R8: A data byte that completes while rx_ready is still 1, with no data_rd in that cycle, replaces rx_data and sets overrun.
- R9: A data_rd pulse in the same cycle as a new byte's completion leaves rx_ready at 1 with the new byte on rx_data, and overrun stays 0.
- R10: A repeated START releases SDA and restarts address recognition, so a new header and low address byte can match again within the same bus session.
- R11: The acknowledge pull-down is applied only during the ninth SCL clock. sda_oe is back at 0 shortly after SCL falls at the end of that clock, and it never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| own_addr | input | 10 | This target's 10-bit address |
| stat_rd | input | 1 | Status read strobe; clears stop_seen, addr_match, overrun |
| data_rd | input | 1 | Data read strobe; clears rx_ready |
| nak_set | input | 1 | Arms a NAK for the next data byte |
| rx_data | output | 8 | Last received data byte |
| rx_ready | output | 1 | Unread data byte present |
| overrun | output | 1 | A byte overwrote unread data |
| addr_match | output | 1 | Full 10-bit address matched |
| stop_seen | output | 1 | STOP or repeated START after a match |
| dir_read | output | 1 | Direction bit of last recognized header (0 = write) |
| nak_armed | output | 1 | NAK pending for next data byte |
| irq | output | 1 | OR of rx_ready, addr_match, stop_seen |

## Verification
The sharpest collision is a host data read landing in the very clock cycle in which the next byte's completion reaches the register stage. There the clear of rx_ready and the set of rx_ready, and possibly overrun, compete. The bench provokes it by counting system clocks from the SCL edge that ends the eighth bit, through the two synchronizer stages and the link register, and pulsing data_rd exactly in the capture cycle. It judges the result at the ports: the new byte must be visible, rx_ready must remain set, and overrun must stay clear. A second overlap, a consumed NAK against a fresh nak_set, is guarded by an assertion. The bench also checks that an overrun byte without a read does raise the flag.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_DATA,
        ST_SKIP
    } link_state_t;

    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] last
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              last_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                last_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[g]};
                last_q  <= chain_q[STAGES-1];
            end
        end
        assign level[g] = chain_q[STAGES-1];
        assign last[g]  = last_q;
    end
endmodule

// File: rtl/i2c10_link.sv
module i2c10_link
    import i2c10_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              nak_armed,
    output logic              sda_oe,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              addr_hit,
    output logic              dir_upd,
    output logic              dir_val,
    output logic              nak_used,
    output logic              stop_evt
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        link_state_t       state;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              ack_ph;
        logic              oe;
        logic              engaged;
        logic              done;
        logic              hit;
        logic              dir_upd;
        logic              dir_val;
        logic              nak_used;
        logic              stop_evt;
    } link_t;

    link_t q, d;
    logic  start_c, stop_c, rise_c, fall_c;

    assign start_c = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
    assign rise_c  = scl_s & ~scl_p;
    assign fall_c  = ~scl_s & scl_p;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.hit      = 1'b0;
        d.dir_upd  = 1'b0;
        d.nak_used = 1'b0;
        d.stop_evt = 1'b0;
        if (start_c || stop_c) begin
            d.stop_evt = q.engaged;
            d.engaged  = 1'b0;
            d.state    = start_c ? ST_ADR_HI : ST_IDLE;
            d.cnt      = '0;
            d.ack_ph   = 1'b0;
            d.oe       = 1'b0;
        end else if (q.state != ST_IDLE) begin
            if (rise_c && !q.ack_ph && q.cnt < LAST_BIT) begin
                d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                d.cnt   = q.cnt + 1'b1;
            end else if (fall_c && q.ack_ph) begin
                d.ack_ph = 1'b0;
                d.oe     = 1'b0;
                d.cnt    = '0;
            end else if (fall_c && q.cnt == LAST_BIT) begin
                d.ack_ph = 1'b1;
                d.oe     = 1'b0;
                d.state  = ST_SKIP;
                case (q.state)
                    ST_ADR_HI: begin
                        if (q.shreg[7:3] == TEN_BIT_PREFIX &&
                            q.shreg[2:1] == own_addr[ADDR_W-1:BYTE_W]) begin
                            d.dir_upd = 1'b1;
                            d.dir_val = q.shreg[0];
                            if (!q.shreg[0]) begin
                                d.oe    = 1'b1;
                                d.state = ST_ADR_LO;
                            end
                        end
                    end
                    ST_ADR_LO: begin
                        if (q.shreg == own_addr[BYTE_W-1:0]) begin
                            d.oe      = 1'b1;
                            d.hit     = 1'b1;
                            d.engaged = 1'b1;
                            d.state   = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        d.done     = 1'b1;
                        d.oe       = ~nak_armed;
                        d.nak_used = nak_armed;
                        d.state    = nak_armed ? ST_SKIP : ST_DATA;
                    end
                    default: d.state = ST_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign byte_done = q.done;
    assign rx_byte   = q.shreg;
    assign addr_hit  = q.hit;
    assign dir_upd   = q.dir_upd;
    assign dir_val   = q.dir_val;
    assign nak_used  = q.nak_used;
    assign stop_evt  = q.stop_evt;

    assert_oe_steady_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(q.oe));
    assert_start_frees_sda_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (!sda_oe && q.cnt == '0));
endmodule

// File: rtl/i2c10_regs.sv
module i2c10_regs
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              addr_hit,
    input  logic              dir_upd,
    input  logic              dir_val,
    input  logic              nak_used,
    input  logic              stop_evt,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              nak_set,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              overrun,
    output logic              addr_match,
    output logic              stop_seen,
    output logic              dir_read,
    output logic              nak_armed,
    output logic              irq
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              rdy;
        logic              ovr;
        logic              match;
        logic              stop;
        logic              dir;
        logic              nak;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (stat_rd) begin
            d.stop  = 1'b0;
            d.match = 1'b0;
            d.ovr   = 1'b0;
        end
        if (addr_hit) d.match = 1'b1;
        if (stop_evt) d.stop  = 1'b1;
        if (dir_upd)  d.dir   = dir_val;
        if (data_rd)  d.rdy   = 1'b0;
        if (byte_done) begin
            d.data = rx_byte;
            d.rdy  = 1'b1;
            if (q.rdy && !data_rd) d.ovr = 1'b1;
        end
        if (nak_used) d.nak = 1'b0;
        if (nak_set)  d.nak = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data    = q.data;
    assign rx_ready   = q.rdy;
    assign overrun    = q.ovr;
    assign addr_match = q.match;
    assign stop_seen  = q.stop;
    assign dir_read   = q.dir;
    assign nak_armed  = q.nak;
    assign irq        = q.rdy | q.match | q.stop;

    assert_read_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !byte_done) |=> !rx_ready);
    assert_unread_byte_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && rx_ready && !data_rd) |=> overrun);
    assert_nak_self_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_used && !nak_set) |=> !nak_armed);
    assert_read_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && data_rd && !overrun && !stat_rd) |=> (rx_ready && !overrun));
endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
    import i2c10_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [9:0] own_addr,
    input  logic       stat_rd,
    input  logic       data_rd,
    input  logic       nak_set,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       overrun,
    output logic       addr_match,
    output logic       stop_seen,
    output logic       dir_read,
    output logic       nak_armed,
    output logic       irq
);
    logic [1:0]        lvl, prv;
    logic              done, hit, dupd, dval, nused, sevt;
    logic [BYTE_W-1:0] rbyte;

    i2c10_sync #(.STAGES(2), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}), .level(lvl), .last(prv)
    );

    i2c10_link #(.ADDR_W(10)) u_link (
        .clk(clk), .rst_n(rst_n),
        .scl_s(lvl[1]), .scl_p(prv[1]), .sda_s(lvl[0]), .sda_p(prv[0]),
        .own_addr(own_addr), .nak_armed(nak_armed),
        .sda_oe(sda_oe), .byte_done(done), .rx_byte(rbyte), .addr_hit(hit),
        .dir_upd(dupd), .dir_val(dval), .nak_used(nused), .stop_evt(sevt)
    );

    i2c10_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .byte_done(done), .rx_byte(rbyte), .addr_hit(hit), .dir_upd(dupd),
        .dir_val(dval), .nak_used(nused), .stop_evt(sevt),
        .stat_rd(stat_rd), .data_rd(data_rd), .nak_set(nak_set),
        .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
        .addr_match(addr_match), .stop_seen(stop_seen), .dir_read(dir_read),
        .nak_armed(nak_armed), .irq(irq)
    );
endmodule

// File: tb/sim_i2c10_slave_rx.sv
module sim_i2c10_slave_rx;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;
    localparam logic [9:0] OWN = 10'h2A5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic stat_rd = 1'b0, data_rd = 1'b0, nak_set = 1'b0;
    logic sda_oe, rx_ready, overrun, addr_match, stop_seen, dir_read, nak_armed, irq;
    logic [7:0] rx_data;
    logic sda_line;
    int checks = 0, fails = 0;

    assign sda_line = m_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    i2c10_slave_rx u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .own_addr(OWN), .stat_rd(stat_rd), .data_rd(data_rd), .nak_set(nak_set),
        .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
        .addr_match(addr_match), .stop_seen(stop_seen), .dir_read(dir_read),
        .nak_armed(nak_armed), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit collide, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
            if (i == 0 && collide) begin
                tick(3); data_rd = 1'b1; tick(1); data_rd = 1'b0; tick(H - 4);
            end else begin
                tick(H);
            end
        end
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        acked = ~sda_line;
        tick(H/2);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic pulse_stat;
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0; tick(1);
    endtask

    task automatic pulse_data;
        data_rd = 1'b1; tick(1); data_rd = 1'b0; tick(1);
    endtask

    task automatic address_me;
        bit a;
        bus_start;
        send_byte(8'hF4, 1'b0, a); chk("R2 header ack", a, 1);
        send_byte(8'hA5, 1'b0, a); chk("R4 low addr ack", a, 1);
        pulse_stat;
    endtask

    task automatic t_reset;
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 flags", {rx_ready, overrun, addr_match, stop_seen, dir_read, nak_armed, irq}, 0);
    endtask

    task automatic t_basic_write;
        bit a;
        bus_start;
        send_byte(8'hF4, 1'b0, a);
        chk("R2 header ack", a, 1);
        chk("R3 dir write", dir_read, 0);
        send_byte(8'hA5, 1'b0, a);
        chk("R4 ack", a, 1);
        chk("R4 addr_match", addr_match, 1);
        chk("R4 irq", irq, 1);
        pulse_stat;
        chk("R7 stat clears match", addr_match, 0);
        send_byte(8'h3C, 1'b0, a);
        chk("R5 data ack", a, 1);
        chk("R5 rx_data", rx_data, 8'h3C);
        chk("R5 rx_ready", rx_ready, 1);
        chk("R11 sda released", sda_oe, 0);
        pulse_data;
        chk("R5 data_rd clears", rx_ready, 0);
        bus_stop;
        chk("R7 stop_seen", stop_seen, 1);
        chk("R7 irq", irq, 1);
        pulse_stat;
        chk("R7 stat clears stop", {stop_seen, irq}, 0);
    endtask

    task automatic t_bad_prefix;
        bit a;
        bus_start;
        send_byte(8'hE4, 1'b0, a); chk("R2 bad prefix nak", a, 0);
        send_byte(8'hA5, 1'b0, a); chk("R2 ignored low", a, 0);
        chk("R2 no match", addr_match, 0);
        send_byte(8'h11, 1'b0, a); chk("R2 ignored data", a, 0);
        chk("R2 no data", rx_ready, 0);
        bus_stop;
        chk("R7 unmatched stop", stop_seen, 0);
    endtask

    task automatic t_bad_upper;
        bit a;
        bus_start;
        send_byte(8'hF2, 1'b0, a); chk("R2 upper bits nak", a, 0);
        bus_stop;
    endtask

    task automatic t_read_dir;
        bit a;
        bus_start;
        send_byte(8'hF5, 1'b0, a);
        chk("R3 read nak", a, 0);
        chk("R3 dir read", dir_read, 1);
        bus_stop;
    endtask

    task automatic t_bad_low;
        bit a;
        bus_start;
        send_byte(8'hF4, 1'b0, a); chk("R3 dir back to write", dir_read, 0);
        send_byte(8'hA4, 1'b0, a); chk("R4 mismatch nak", a, 0);
        chk("R4 no match flag", addr_match, 0);
        send_byte(8'h55, 1'b0, a); chk("R4 data ignored", {a, rx_ready}, 0);
        bus_stop;
        chk("R7 no stop flag", stop_seen, 0);
    endtask

    task automatic t_nak;
        bit a;
        address_me;
        nak_set = 1'b1; tick(1); nak_set = 1'b0; tick(1);
        chk("R6 armed", nak_armed, 1);
        send_byte(8'h77, 1'b0, a);
        chk("R6 nak sent", a, 0);
        chk("R6 stored", {rx_ready, rx_data}, {1'b1, 8'h77});
        chk("R6 self clear", nak_armed, 0);
        pulse_data;
        send_byte(8'h88, 1'b0, a);
        chk("R6 later ignored", {a, rx_ready}, 0);
        bus_stop;
        chk("R7 stop after nak", stop_seen, 1);
        pulse_stat;
    endtask

    task automatic t_overrun;
        bit a;
        address_me;
        send_byte(8'h01, 1'b0, a);
        send_byte(8'h02, 1'b0, a);
        chk("R8 ack", a, 1);
        chk("R8 overwrite", rx_data, 8'h02);
        chk("R8 overrun", {overrun, rx_ready}, 2'b11);
        pulse_stat;
        chk("R7 stat clears overrun", overrun, 0);
        pulse_data;
        bus_stop;
        pulse_stat;
    endtask

    task automatic t_restart;
        bit a;
        address_me;
        send_byte(8'h10, 1'b0, a);
        pulse_data;
        bus_start;
        chk("R7 restart sets stop", stop_seen, 1);
        chk("R10 sda free", sda_oe, 0);
        pulse_stat;
        send_byte(8'hF4, 1'b0, a); chk("R10 header again", a, 1);
        send_byte(8'hA5, 1'b0, a); chk("R10 rematch", {a, addr_match}, 2'b11);
        send_byte(8'h20, 1'b0, a); chk("R10 data", rx_data, 8'h20);
        pulse_data;
        bus_stop;
        pulse_stat;
    endtask

    task automatic t_collide;
        bit a;
        address_me;
        send_byte(8'h31, 1'b0, a);
        chk("R9 first byte", rx_ready, 1);
        send_byte(8'h32, 1'b1, a);
        chk("R9 new byte", rx_data, 8'h32);
        chk("R9 ready kept", rx_ready, 1);
        chk("R9 no overrun", overrun, 0);
        pulse_data;
        bus_stop;
        pulse_stat;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset;
        t_basic_write;
        t_bad_prefix;
        t_bad_upper;
        t_read_dir;
        t_bad_low;
        t_nak;
        t_overrun;
        t_restart;
        t_collide;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule